// File: doc/BRIEF.md
# Octal Double-Data-Rate Mode Switch Sequencer

This block moves a serial NOR flash between its extended single-line protocol (1-1-1) and the eight-line double-data-rate protocol (8D-8D-8D), then proves the move worked. On a start request it issues a short series of command descriptors to a lower-level transaction engine. The series consists of write-enable commands, writes to volatile configuration registers, and a final read of the device identification bytes in the protocol just selected. The returned identification bytes are compared with an expected value supplied on an input.

The two directions are not mirror images. Going to octal writes the dummy-cycle register and the mode register one at a time, while still in single-line protocol. Going back issues a single two-byte burst in octal protocol, because a one-byte transfer is not legal in double-data-rate mode. The block keeps one internal mode flag. That flag changes only when the identification check passes, so every later command and the array fast-read settings follow the confirmed protocol. Any transaction error stops the series at once and is reported.

Top module: `octal_mode_switch`

## Requirements
- R1: After reset the confirmed mode flag is 0 (single-line), and busy_o, done_o and cmd_valid_o are 0.
- R2: A switch to octal (target_octal_i=1) issues, all with cmd_octal_o=0: write-enable (opcode 0x06, no address, no data); a register write (opcode 0x81, ADDR_BYTES address bytes, address 0x01, no dummy, 1 byte, value 20 in cmd_wdata_o[7:0]); a second write-enable; a register write to address 0x00 with the 1 byte 0xE7.
- R3: After these writes, the octal switch reads the identification in octal protocol: opcode 0x9F, cmd_octal_o=1, cmd_read_o=1, 0 address bytes, 8 dummy cycles, ID_BYTES data bytes.
- R4: A switch back (target_octal_i=0) issues, all in octal protocol, a write-enable and then one register write to address 0x00 of 2 bytes, first 0xFF (cmd_wdata_o[7:0]) then 0x1F (cmd_wdata_o[15:8]), no dummy. It then reads the identification with cmd_octal_o=0, 0 address bytes, 0 dummy cycles and ID_BYTES bytes.
- R5: Every octal command carries an extension byte cmd_ext_o equal to its opcode, and every single-line command carries cmd_ext_o=0x00.
- R6: The identification check covers all ID_BYTES bytes (first received byte in bits [7:0]). A match ends with ok_o=1 and err_code_o=0, and any mismatching byte ends with ok_o=0 and err_code_o=2.
- R7: A response with rsp_err_i=1 ends the series with no further command, and gives ok_o=0 and err_code_o=1. done_o is raised in the cycle after that response.
- R8: octal_mode_o takes the requested value only when the identification check passes, at the same edge that raises done_o. An error or a mismatch leaves it unchanged.
- R9: A start whose target equals the confirmed mode issues no command and raises done_o with ok_o=1 in the next cycle.
- R10: The array fast-read setting follows the confirmed mode: opcode 0xFD with 20 dummy cycles in octal mode, and opcode 0x0B with 8 dummy cycles in single-line mode.
- R11: A descriptor holds stable while cmd_valid_o=1 and cmd_ready_i=0. start_i is ignored while busy_o=1, and done_o is a one-cycle pulse, with ok_o and err_code_o held until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a mode switch |
| target_octal_i | input | 1 | Requested mode: 1 octal DDR, 0 single-line |
| exp_id_i | input | 8*ID_BYTES | Expected identification bytes, first byte in [7:0] |
| cmd_valid_o | output | 1 | Descriptor valid |
| cmd_ready_i | input | 1 | Engine accepts the descriptor |
| cmd_octal_o | output | 1 | Protocol of the command: 1 octal DDR, 0 single-line |
| cmd_opcode_o | output | 8 | Command opcode |
| cmd_ext_o | output | 8 | Command extension byte |
| cmd_addr_o | output | 32 | Register address |
| cmd_addr_bytes_o | output | 3 | Number of address bytes |
| cmd_dummy_o | output | 5 | Dummy cycles |
| cmd_read_o | output | 1 | 1 read data phase, 0 write data phase |
| cmd_len_o | output | 3 | Data bytes |
| cmd_wdata_o | output | 16 | Write data, first byte in [7:0] |
| rsp_done_i | input | 1 | Transaction finished |
| rsp_err_i | input | 1 | Transaction failed, valid with rsp_done_i |
| rsp_rdata_i | input | 8*ID_BYTES | Read bytes, valid with rsp_done_i |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle end pulse |
| ok_o | output | 1 | Result of the last series |
| err_code_o | output | 2 | 0 none, 1 transaction error, 2 identification mismatch |
| octal_mode_o | output | 1 | Confirmed protocol flag |
| fr_opcode_o | output | 8 | Array fast-read opcode for the confirmed mode |
| fr_dummy_o | output | 5 | Array fast-read dummy cycles for the confirmed mode |

## Verification
The first descriptor of a series appears one cycle after the start edge, and each following descriptor appears one cycle after the response to the previous one. done_o, ok_o, err_code_o and octal_mode_o all change together one cycle after the last response, or one cycle after the start when no command is needed. The bench drives inputs and samples outputs on the falling edge. It checks the done flag in the cycle after every response: 1 after the last or a failed response, and 0 otherwise. It then checks the pulse has fallen one cycle later. A flash model in the bench acts only on commands whose protocol matches its own current mode. A wrong protocol or a wrong register byte therefore shows up as a wrong identification or a wrong register value.

// File: rtl/octal_mode_switch.sv
module octal_mode_switch #(
  parameter int ADDR_BYTES = 4,
  parameter int ID_BYTES   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    target_octal_i,
  input  logic [8*ID_BYTES-1:0]   exp_id_i,
  output logic                    cmd_valid_o,
  input  logic                    cmd_ready_i,
  output logic                    cmd_octal_o,
  output logic [7:0]              cmd_opcode_o,
  output logic [7:0]              cmd_ext_o,
  output logic [31:0]             cmd_addr_o,
  output logic [2:0]              cmd_addr_bytes_o,
  output logic [4:0]              cmd_dummy_o,
  output logic                    cmd_read_o,
  output logic [2:0]              cmd_len_o,
  output logic [15:0]             cmd_wdata_o,
  input  logic                    rsp_done_i,
  input  logic                    rsp_err_i,
  input  logic [8*ID_BYTES-1:0]   rsp_rdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    ok_o,
  output logic [1:0]              err_code_o,
  output logic                    octal_mode_o,
  output logic [7:0]              fr_opcode_o,
  output logic [4:0]              fr_dummy_o
);

  localparam logic [2:0] ABYTES   = 3'(ADDR_BYTES);
  localparam logic [2:0] IDLEN    = 3'(ID_BYTES);
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRREG = 8'h81;
  localparam logic [7:0] OP_RDID  = 8'h9F;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t        st_q;
  logic [2:0] step_q;
  logic       to_oct_q, mode_q, done_q, ok_q;
  logic [1:0] code_q;
  logic       last_step, id_match;

  assign last_step = (step_q == (to_oct_q ? 3'd4 : 3'd2));
  assign id_match  = (rsp_rdata_i == exp_id_i);

  assign busy_o       = (st_q != S_IDLE);
  assign cmd_valid_o  = (st_q == S_ISSUE);
  assign done_o       = done_q;
  assign ok_o         = ok_q;
  assign err_code_o   = code_q;
  assign octal_mode_o = mode_q;
  assign fr_opcode_o  = mode_q ? 8'hFD : 8'h0B;
  assign fr_dummy_o   = mode_q ? 5'd20 : 5'd8;

  assign cmd_octal_o = last_step ? to_oct_q : mode_q;
  assign cmd_ext_o   = cmd_octal_o ? cmd_opcode_o : 8'h00;

  always_comb begin
    cmd_opcode_o     = 8'h00;
    cmd_addr_o       = 32'h0;
    cmd_addr_bytes_o = 3'd0;
    cmd_dummy_o      = 5'd0;
    cmd_read_o       = 1'b0;
    cmd_len_o        = 3'd0;
    cmd_wdata_o      = 16'h0;
    case ({to_oct_q, step_q})
      {1'b1, 3'd0}, {1'b1, 3'd2}, {1'b0, 3'd0}: cmd_opcode_o = OP_WREN;
      {1'b1, 3'd1}: begin
        cmd_opcode_o     = OP_WRREG;
        cmd_addr_o       = 32'h1;
        cmd_addr_bytes_o = ABYTES;
        cmd_len_o        = 3'd1;
        cmd_wdata_o      = 16'd20;
      end
      {1'b1, 3'd3}: begin
        cmd_opcode_o     = OP_WRREG;
        cmd_addr_bytes_o = ABYTES;
        cmd_len_o        = 3'd1;
        cmd_wdata_o      = 16'h00E7;
      end
      {1'b0, 3'd1}: begin
        cmd_opcode_o     = OP_WRREG;
        cmd_addr_bytes_o = ABYTES;
        cmd_len_o        = 3'd2;
        cmd_wdata_o      = 16'h1FFF;
      end
      {1'b1, 3'd4}, {1'b0, 3'd2}: begin
        cmd_opcode_o = OP_RDID;
        cmd_read_o   = 1'b1;
        cmd_len_o    = IDLEN;
        cmd_dummy_o  = to_oct_q ? 5'd8 : 5'd0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      step_q   <= 3'd0;
      to_oct_q <= 1'b0;
      mode_q   <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      code_q   <= 2'd0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          if (target_octal_i == mode_q) begin
            done_q <= 1'b1;
            ok_q   <= 1'b1;
            code_q <= 2'd0;
          end else begin
            st_q     <= S_ISSUE;
            step_q   <= 3'd0;
            to_oct_q <= target_octal_i;
          end
        end
        S_ISSUE: if (cmd_ready_i) st_q <= S_WAIT;
        S_WAIT: if (rsp_done_i) begin
          if (rsp_err_i) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            ok_q   <= 1'b0;
            code_q <= 2'd1;
          end else if (last_step) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            ok_q   <= id_match;
            code_q <= id_match ? 2'd0 : 2'd2;
            if (id_match) mode_q <= to_oct_q;
          end else begin
            step_q <= step_q + 3'd1;
            st_q   <= S_ISSUE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o);

  a_r11_desc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_opcode_o) &&
      $stable(cmd_octal_o) && $stable(cmd_addr_o) && $stable(cmd_len_o) &&
      $stable(cmd_wdata_o) && $stable(cmd_dummy_o));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_mode_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(octal_mode_o) |-> done_o && ok_o);

  a_r7_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !cmd_valid_o && rsp_done_i && rsp_err_i |=>
      done_o && !ok_o && (err_code_o == 2'd1) && !cmd_valid_o);

  a_r9_same_mode: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (target_octal_i == octal_mode_o) |=>
      done_o && ok_o && !busy_o);

  a_r6_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !ok_o |-> err_code_o != 2'd0);

endmodule

// File: tb/octal_mode_switch_tb.sv
module octal_mode_switch_tb;
  localparam int CLK_P      = 10;
  localparam int ADDR_BYTES = 4;
  localparam int ID_BYTES   = 3;
  localparam int IDW        = 8 * ID_BYTES;
  localparam int LAT        = 2;
  localparam int NV         = 14;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, target_octal_i = 0;
  logic [IDW-1:0] exp_id_i = '0, rsp_rdata_i = '0;
  logic cmd_valid_o, cmd_ready_i = 0, cmd_octal_o, cmd_read_o;
  logic [7:0] cmd_opcode_o, cmd_ext_o, fr_opcode_o;
  logic [31:0] cmd_addr_o;
  logic [2:0] cmd_addr_bytes_o, cmd_len_o;
  logic [4:0] cmd_dummy_o, fr_dummy_o;
  logic [15:0] cmd_wdata_o;
  logic rsp_done_i = 0, rsp_err_i = 0;
  logic busy_o, done_o, ok_o, octal_mode_o;
  logic [1:0] err_code_o;

  always #(CLK_P/2) clk = ~clk;

  octal_mode_switch #(.ADDR_BYTES(ADDR_BYTES), .ID_BYTES(ID_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_octal_i(target_octal_i),
    .exp_id_i(exp_id_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_octal_o(cmd_octal_o), .cmd_opcode_o(cmd_opcode_o), .cmd_ext_o(cmd_ext_o),
    .cmd_addr_o(cmd_addr_o), .cmd_addr_bytes_o(cmd_addr_bytes_o),
    .cmd_dummy_o(cmd_dummy_o), .cmd_read_o(cmd_read_o), .cmd_len_o(cmd_len_o),
    .cmd_wdata_o(cmd_wdata_o), .rsp_done_i(rsp_done_i), .rsp_err_i(rsp_err_i),
    .rsp_rdata_i(rsp_rdata_i), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
    .err_code_o(err_code_o), .octal_mode_o(octal_mode_o),
    .fr_opcode_o(fr_opcode_o), .fr_dummy_o(fr_dummy_o));

  typedef struct packed {
    logic       to_oct;
    logic [2:0] err_at;
    logic       bad;
    logic       ok;
    logic [1:0] code;
    logic       mode;
    logic [2:0] ncmd;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd7, 1'b0, 1'b1, 2'd0, 1'b1, 3'd5},
    '{1'b1, 3'd7, 1'b0, 1'b1, 2'd0, 1'b1, 3'd0},
    '{1'b0, 3'd7, 1'b0, 1'b1, 2'd0, 1'b0, 3'd3},
    '{1'b1, 3'd2, 1'b0, 1'b0, 2'd1, 1'b0, 3'd3},
    '{1'b1, 3'd7, 1'b1, 1'b0, 2'd2, 1'b0, 3'd5},
    '{1'b1, 3'd7, 1'b0, 1'b1, 2'd0, 1'b1, 3'd5},
    '{1'b0, 3'd0, 1'b0, 1'b0, 2'd1, 1'b1, 3'd1},
    '{1'b0, 3'd1, 1'b0, 1'b0, 2'd1, 1'b1, 3'd2},
    '{1'b0, 3'd7, 1'b0, 1'b1, 2'd0, 1'b0, 3'd3},
    '{1'b0, 3'd7, 1'b0, 1'b1, 2'd0, 1'b0, 3'd0},
    '{1'b1, 3'd4, 1'b0, 1'b0, 2'd1, 1'b0, 3'd5},
    '{1'b1, 3'd7, 1'b0, 1'b1, 2'd0, 1'b1, 3'd5},
    '{1'b0, 3'd7, 1'b1, 1'b0, 2'd2, 1'b1, 3'd3},
    '{1'b0, 3'd7, 1'b0, 1'b1, 2'd0, 1'b0, 3'd3}
  };

  int checks = 0, errors = 0;
  logic fl_oct = 0, fl_wel = 0;
  logic [7:0] fl_reg0 = 8'hFF, fl_reg1 = 8'h1F;
  logic dmode = 0;

  function automatic logic [IDW-1:0] flash_id();
    logic [IDW-1:0] v;
    for (int i = 0; i < ID_BYTES; i++) v[8*i +: 8] = 8'hC3 + 8'(i * 29);
    return v;
  endfunction

  function automatic logic [63:0] exp_desc(logic to_oct, int step, logic dm);
    logic o; logic [7:0] op; logic [7:0] a; logic [2:0] ab, len; logic [4:0] dmy;
    logic rd; logic [15:0] wd;
    int last = to_oct ? 4 : 2;
    o = (step == last) ? to_oct : dm;
    op = 8'h06; a = 8'h00; ab = 3'd0; len = 3'd0; dmy = 5'd0; rd = 1'b0; wd = 16'h0;
    if (step == last) begin
      op = 8'h9F; rd = 1'b1; len = 3'(ID_BYTES); dmy = to_oct ? 5'd8 : 5'd0;
    end else if (step == 1 || step == 3) begin
      op = 8'h81; ab = 3'(ADDR_BYTES);
      if (!to_oct) begin len = 3'd2; wd = 16'h1FFF; end
      else if (step == 1) begin a = 8'h01; len = 3'd1; wd = 16'd20; end
      else begin len = 3'd1; wd = 16'h00E7; end
    end
    return {o, op, o ? op : 8'h00, a, ab, dmy, rd, len, wd};
  endfunction

  task automatic chk(input logic cond, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    int ncmd = 0;
    logic [63:0] act;
    logic c_oct; logic [7:0] c_op; logic [7:0] c_a; logic [2:0] c_len;
    logic [15:0] c_wd; logic err_now, final_rsp;
    target_octal_i = v.to_oct;
    exp_id_i = v.bad ? (flash_id() ^ (IDW'(1) << (IDW-8))) : flash_id();
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (!done_o && ncmd < 8) begin
      if (cmd_valid_o) begin
        act = {cmd_octal_o, cmd_opcode_o, cmd_ext_o, cmd_addr_o[7:0], cmd_addr_bytes_o,
               cmd_dummy_o, cmd_read_o, cmd_len_o, cmd_wdata_o};
        chk(act == exp_desc(v.to_oct, ncmd, dmode),
            v.to_oct ? "R2/R3/R5" : "R4/R5", $sformatf("vec %0d cmd %0d", idx, ncmd),
            act, exp_desc(v.to_oct, ncmd, dmode));
        if (idx == 0 && ncmd == 1) begin
          start_i = 1; target_octal_i = 1'b0;
          repeat (3) @(negedge clk);
          start_i = 0;
          chk(cmd_valid_o && {cmd_octal_o, cmd_opcode_o, cmd_ext_o, cmd_addr_o[7:0],
              cmd_addr_bytes_o, cmd_dummy_o, cmd_read_o, cmd_len_o, cmd_wdata_o} == act,
              "R11", "descriptor held while stalled", {63'd0, cmd_valid_o}, 64'd1);
        end
        c_oct = cmd_octal_o; c_op = cmd_opcode_o; c_a = cmd_addr_o[7:0];
        c_len = cmd_len_o; c_wd = cmd_wdata_o;
        cmd_ready_i = 1;
        @(negedge clk);
        cmd_ready_i = 0;
        repeat (LAT) @(negedge clk);
        err_now = (3'(ncmd) == v.err_at);
        rsp_err_i = err_now;
        rsp_rdata_i = '1;
        if (!err_now && c_oct == fl_oct) begin
          if (c_op == 8'h06) fl_wel = 1;
          else if (c_op == 8'h9F) rsp_rdata_i = flash_id();
          else if (c_op == 8'h81 && fl_wel) begin
            for (int b = 0; b < int'(c_len); b++) begin
              if (int'(c_a) + b == 0) fl_reg0 = c_wd[8*b +: 8];
              if (int'(c_a) + b == 1) fl_reg1 = c_wd[8*b +: 8];
            end
            fl_wel = 0;
            if (c_a == 8'h00) fl_oct = (fl_reg0 == 8'hE7);
          end
        end
        rsp_done_i = 1;
        @(negedge clk);
        rsp_done_i = 0; rsp_err_i = 0;
        ncmd++;
        final_rsp = err_now || (ncmd == (v.to_oct ? 5 : 3));
        chk(done_o == final_rsp, "R7", $sformatf("vec %0d done timing after cmd %0d", idx, ncmd),
            {63'd0, done_o}, {63'd0, final_rsp});
      end else if (!done_o) @(negedge clk);
    end
    chk(ncmd == int'(v.ncmd), v.ncmd == 0 ? "R9" : "R7", $sformatf("vec %0d command count", idx),
        64'(ncmd), 64'(v.ncmd));
    chk(done_o && ok_o == v.ok && err_code_o == v.code, "R6",
        $sformatf("vec %0d done/ok/code", idx), {59'd0, done_o, ok_o, err_code_o},
        {60'd1, v.ok, v.code});
    chk(octal_mode_o == v.mode, "R8", $sformatf("vec %0d mode", idx),
        {63'd0, octal_mode_o}, {63'd0, v.mode});
    chk(fr_opcode_o == (v.mode ? 8'hFD : 8'h0B) && fr_dummy_o == (v.mode ? 5'd20 : 5'd8),
        "R10", $sformatf("vec %0d fast read", idx), {fr_opcode_o, 3'd0, fr_dummy_o},
        {v.mode ? 8'hFD : 8'h0B, 3'd0, v.mode ? 5'd20 : 5'd8});
    dmode = v.mode;
    @(negedge clk);
    chk(!done_o && ok_o == v.ok && err_code_o == v.code && !busy_o, "R11",
        $sformatf("vec %0d done pulse and held result", idx),
        {60'd0, done_o, ok_o, err_code_o}, {61'd0, v.ok, v.code});
  endtask

  task automatic run_all();
    repeat (2) @(negedge clk);
    chk(!octal_mode_o && !busy_o && !done_o && !cmd_valid_o, "R1", "reset state",
        {60'd0, octal_mode_o, busy_o, done_o, cmd_valid_o}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(fr_opcode_o == 8'h0B && fr_dummy_o == 5'd8, "R10", "fast read after reset",
        {fr_opcode_o, 3'd0, fr_dummy_o}, {8'h0B, 3'd0, 5'd8});
    for (int i = 0; i < NV; i++) begin
      run_vec(i, VECS[i]);
      if (i == 0) chk(fl_reg1 == 8'd20 && fl_oct, "R2", "flash dummy reg after enable",
                      {56'd0, fl_reg1}, 64'd20);
      if (i == 2) chk(fl_reg1 == 8'h1F && !fl_oct, "R4", "flash dummy reg after disable",
                      {56'd0, fl_reg1}, 64'h1F);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule